// File: doc/BRIEF.md
# Descriptor Ring DMA Engine

This block is the hardware side of a descriptor-driven DMA engine for an Ethernet controller. It walks a receive ring and a transmit ring that both live in memory. Each ring is a run of two-word descriptors, starting at a base address that software supplies. Word 0 of a descriptor holds a 16-bit status field in bits 31:16 and a 16-bit byte length in bits 15:0. Word 1 holds the buffer pointer, a word address. Frame data is stored one byte per memory word, in bits 7:0.

The receive side pulls bytes from the MAC byte stream into the buffers of descriptors that software has marked empty. It may spread one frame over several descriptors. It writes back status and length, and the write-back hands the descriptor back to software. The transmit side reads the buffers of descriptors that software has marked ready and streams their bytes to the MAC. It then hands each descriptor back. Each ring has its own memory port. Both ports have a one-cycle read latency.

When an engine reaches a descriptor it does not own, that ring goes idle. It stays idle until software writes the poll register for that ring with bit 24 set.

Top module: `dring_dma`

## Requirements
- R1: While reset is held, and right after it, both rings are inactive, `rx_ready` and `tx_valid` are low, and neither done pulse is raised.
- R2: A poll write with bit 24 of `poll_wdata` set activates the addressed ring. The engine then fetches the descriptor at base + 2 × index. A poll write with bit 24 clear leaves the ring inactive.
- R3: The receive engine stores data only into a descriptor whose ownership bit (status bit 31 of word 0) is set. On reaching a descriptor with bit 31 clear, the ring goes inactive and `rx_ready` drops. That descriptor is left unwritten, even in the middle of a frame.
- R4: Receive write-back clears bit 31 and keeps the wrap bit (bit 29). It sets the last bit (bit 27) only on the final descriptor of a frame. The final descriptor reports the whole frame length, FCS bytes included. Every earlier descriptor reports BUF_BYTES.
- R5: Received byte k of a descriptor is written to buffer pointer + k, in bits 7:0.
- R6: After a descriptor whose wrap bit is set, the next index is 0. Otherwise the index advances by one.
- R7: Bytes beyond MAX_FRAME in one frame are discarded, and the final descriptor gets the error bit (bit 16) set with length MAX_FRAME. An `rx_err` flag on the last byte also sets bit 16.
- R8: The transmit engine sends only descriptors whose ready bit (bit 31) is set, and stops the ring on the first one that is clear. It streams `length` bytes from the buffer and holds each byte until `tx_ready`. `tx_last` marks the final byte only when status bit 27 is set, and `tx_crc` follows status bit 26.
- R9: Transmit write-back clears bit 31 and keeps every other status bit and the length.
- R10: `rx_done` rises for exactly one clock in the cycle after the write-back of a frame's final descriptor. `tx_done` does the same after the write-back of a descriptor with bit 27 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_ring_base | input | AW | Word address of receive descriptor 0 |
| tx_ring_base | input | AW | Word address of transmit descriptor 0 |
| rx_poll_wr | input | 1 | Write strobe for the receive poll register |
| tx_poll_wr | input | 1 | Write strobe for the transmit poll register |
| poll_wdata | input | 32 | Poll write data; bit 24 requests activity |
| rx_active | output | 1 | Receive ring is active |
| tx_active | output | 1 | Transmit ring is active |
| rxm_req | output | 1 | Receive memory access |
| rxm_we | output | 1 | Receive memory write enable |
| rxm_addr | output | AW | Receive memory word address |
| rxm_wdata | output | 32 | Receive memory write data |
| rxm_rdata | input | 32 | Receive memory read data, one cycle after the request |
| txm_req | output | 1 | Transmit memory access |
| txm_we | output | 1 | Transmit memory write enable |
| txm_addr | output | AW | Transmit memory word address |
| txm_wdata | output | 32 | Transmit memory write data |
| txm_rdata | input | 32 | Transmit memory read data, one cycle after the request |
| rx_valid | input | 1 | MAC receive byte valid |
| rx_data | input | 8 | MAC receive byte |
| rx_last | input | 1 | Final byte of the frame (FCS included) |
| rx_err | input | 1 | Frame error, sampled with the last byte |
| rx_ready | output | 1 | Engine accepts a receive byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_crc | output | 1 | MAC should append the FCS |
| tx_ready | input | 1 | MAC accepts the transmit byte |
| rx_done | output | 1 | One-cycle receive frame done pulse |
| tx_done | output | 1 | One-cycle transmit frame done pulse |

## Verification
A wrong ring index shows up as write-backs landing on the wrong descriptor word. This is visible in memory within a few cycles of the next frame boundary, and the wrap case (R6) exposes it at once. A stale ownership decision shows up either as bytes stored into a descriptor software still holds, or as `rx_ready` staying high after the stop. The stall partway through a frame checks this against memory before software re-arms the descriptor. Counter faults in length or frame accounting show up as wrong length fields and a misplaced last or error bit. Transmit faults show up at the very next stream handshake, as a wrong byte, a misplaced `tx_last` or a missing hold under backpressure.

// File: rtl/dring_pkg.sv
package dring_pkg;
   // status bit positions within descriptor word 0 (software decodes these)
   localparam int OWN_B   = 31;   // empty (rx) / ready (tx)
   localparam int WRAP_B  = 29;
   localparam int LAST_B  = 27;
   localparam int TXCRC_B = 26;
   localparam int ERR_B   = 16;
   localparam int POLL_B  = 24;   // bit of the poll write that requests activity

   typedef enum logic [2:0] {
      RX_IDLE, RX_F0, RX_F1, RX_F2, RX_DATA, RX_WB
   } rx_st_e;

   typedef enum logic [2:0] {
      TX_IDLE, TX_F0, TX_F1, TX_F2, TX_RD, TX_LAT, TX_OUT, TX_WB
   } tx_st_e;
endpackage

// File: rtl/dring_ptr.sv
module dring_ptr
   import dring_pkg::*;
#(
   parameter int AW    = 16,
   parameter int IDX_W = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] base,
   input  logic          poll_wr,
   input  logic [31:0]   poll_data,
   input  logic          stop,
   input  logic          advance,
   input  logic          wrap_now,
   output logic          active,
   output logic [AW-1:0] desc_addr
);
   logic [IDX_W-1:0] idx;
   logic             poll_hit;

   assign poll_hit  = poll_wr && poll_data[POLL_B];
   assign desc_addr = base + AW'({idx, 1'b0});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
      end else begin
         if (poll_hit)  active <= 1'b1;
         else if (stop) active <= 1'b0;
         if (advance)   idx <= wrap_now ? '0 : idx + 1'b1;
      end
   end

   logic unused_poll;
   assign unused_poll = ^{poll_data[31:POLL_B+1], poll_data[POLL_B-1:0]};

   p_poll_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      poll_hit |=> active);
   p_stop_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !poll_hit) |=> !active);
   p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && wrap_now) |=> (desc_addr == base));
endmodule

// File: rtl/dring_rx.sv
module dring_rx
   import dring_pkg::*;
#(
   parameter int AW        = 16,
   parameter int BUF_BYTES = 128,
   parameter int MAX_FRAME = 1522
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic [AW-1:0] desc_addr,
   output logic          stop,
   output logic          advance,
   output logic          wrap_now,
   input  logic          rx_valid,
   input  logic [7:0]    rx_data,
   input  logic          rx_last,
   input  logic          rx_err,
   output logic          rx_ready,
   output logic          rx_done,
   output logic          m_req,
   output logic          m_we,
   output logic [AW-1:0] m_addr,
   output logic [31:0]   m_wdata,
   input  logic [31:0]   m_rdata
);
   localparam logic [15:0] BUF_LEN = 16'(BUF_BYTES);
   localparam logic [15:0] MAX_LEN = 16'(MAX_FRAME);

   rx_st_e        st;
   logic [AW-1:0] ptr;
   logic [15:0]   cnt, total;
   logic          wrap_f, err_f, final_f, keep;
   logic [31:0]   wb_word;

   assign keep     = total < MAX_LEN;
   assign rx_ready = (st == RX_DATA);
   assign wrap_now = wrap_f;

   always_comb begin
      wb_word         = '0;
      wb_word[WRAP_B] = wrap_f;
      wb_word[LAST_B] = final_f;
      wb_word[ERR_B]  = final_f && err_f;
      wb_word[15:0]   = final_f ? total : BUF_LEN;
   end

   always_comb begin
      m_req   = 1'b0;
      m_we    = 1'b0;
      m_addr  = desc_addr;
      m_wdata = '0;
      stop    = 1'b0;
      advance = 1'b0;
      unique case (st)
         RX_F0: m_req = 1'b1;
         RX_F1: begin
            if (m_rdata[OWN_B]) begin
               m_req  = 1'b1;
               m_addr = desc_addr + 1'b1;
            end else begin
               stop = 1'b1;
            end
         end
         RX_DATA: begin
            if (rx_valid && keep) begin
               m_req   = 1'b1;
               m_we    = 1'b1;
               m_addr  = ptr + AW'(cnt);
               m_wdata = {24'd0, rx_data};
            end
         end
         RX_WB: begin
            m_req   = 1'b1;
            m_we    = 1'b1;
            m_wdata = wb_word;
            advance = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= RX_IDLE;
         ptr     <= '0;
         cnt     <= '0;
         total   <= '0;
         wrap_f  <= 1'b0;
         err_f   <= 1'b0;
         final_f <= 1'b0;
         rx_done <= 1'b0;
      end else begin
         rx_done <= 1'b0;
         unique case (st)
            RX_IDLE: if (active) st <= RX_F0;
            RX_F0:   st <= RX_F1;
            RX_F1: begin
               if (m_rdata[OWN_B]) begin
                  wrap_f <= m_rdata[WRAP_B];
                  st     <= RX_F2;
               end else begin
                  st <= RX_IDLE;
               end
            end
            RX_F2: begin
               ptr <= m_rdata[AW-1:0];
               cnt <= '0;
               st  <= RX_DATA;
            end
            RX_DATA: begin
               if (rx_valid) begin
                  if (keep) begin
                     cnt   <= cnt + 1'b1;
                     total <= total + 1'b1;
                  end else begin
                     err_f <= 1'b1;
                  end
                  if (rx_last) begin
                     final_f <= 1'b1;
                     if (rx_err) err_f <= 1'b1;
                     st <= RX_WB;
                  end else if (keep && (cnt == BUF_LEN - 1'b1)) begin
                     final_f <= 1'b0;
                     st      <= RX_WB;
                  end
               end
            end
            RX_WB: begin
               rx_done <= final_f;
               final_f <= 1'b0;
               if (final_f) begin
                  total <= '0;
                  err_f <= 1'b0;
               end
               st <= RX_IDLE;
            end
            default: st <= RX_IDLE;
         endcase
      end
   end

   logic unused_rd;
   assign unused_rd = ^{m_rdata[30], m_rdata[28:AW]};

   p_total_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      total <= MAX_LEN);
   p_ready_needs_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |-> active);
   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);
   p_done_after_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_done) |-> $past(m_req && m_we && advance));
endmodule

// File: rtl/dring_tx.sv
module dring_tx
   import dring_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic [AW-1:0] desc_addr,
   output logic          stop,
   output logic          advance,
   output logic          wrap_now,
   output logic          tx_valid,
   output logic [7:0]    tx_data,
   output logic          tx_last,
   output logic          tx_crc,
   input  logic          tx_ready,
   output logic          tx_done,
   output logic          m_req,
   output logic          m_we,
   output logic [AW-1:0] m_addr,
   output logic [31:0]   m_wdata,
   input  logic [31:0]   m_rdata
);
   tx_st_e        st;
   logic [AW-1:0] ptr;
   logic [15:0]   len, cnt, stat;
   logic [7:0]    byte_q;
   logic          end_byte;

   assign end_byte = (cnt + 1'b1) == len;
   assign tx_valid = (st == TX_OUT);
   assign tx_data  = byte_q;
   assign tx_last  = tx_valid && end_byte && stat[LAST_B-16];
   assign tx_crc   = tx_valid && stat[TXCRC_B-16];
   assign wrap_now = stat[WRAP_B-16];

   always_comb begin
      m_req   = 1'b0;
      m_we    = 1'b0;
      m_addr  = desc_addr;
      m_wdata = '0;
      stop    = 1'b0;
      advance = 1'b0;
      unique case (st)
         TX_F0: m_req = 1'b1;
         TX_F1: begin
            if (m_rdata[OWN_B]) begin
               m_req  = 1'b1;
               m_addr = desc_addr + 1'b1;
            end else begin
               stop = 1'b1;
            end
         end
         TX_RD: begin
            m_req  = 1'b1;
            m_addr = ptr + AW'(cnt);
         end
         TX_WB: begin
            m_req   = 1'b1;
            m_we    = 1'b1;
            m_wdata = {1'b0, stat[14:0], len};
            advance = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= TX_IDLE;
         ptr     <= '0;
         len     <= '0;
         cnt     <= '0;
         stat    <= '0;
         byte_q  <= '0;
         tx_done <= 1'b0;
      end else begin
         tx_done <= 1'b0;
         unique case (st)
            TX_IDLE: if (active) st <= TX_F0;
            TX_F0:   st <= TX_F1;
            TX_F1: begin
               if (m_rdata[OWN_B]) begin
                  stat <= m_rdata[31:16];
                  len  <= m_rdata[15:0];
                  st   <= TX_F2;
               end else begin
                  st <= TX_IDLE;
               end
            end
            TX_F2: begin
               ptr <= m_rdata[AW-1:0];
               cnt <= '0;
               st  <= (len == 16'd0) ? TX_WB : TX_RD;
            end
            TX_RD:  st <= TX_LAT;
            TX_LAT: begin
               byte_q <= m_rdata[7:0];
               st     <= TX_OUT;
            end
            TX_OUT: begin
               if (tx_ready) begin
                  cnt <= cnt + 1'b1;
                  st  <= end_byte ? TX_WB : TX_RD;
               end
            end
            TX_WB: begin
               tx_done <= stat[LAST_B-16];
               st      <= TX_IDLE;
            end
            default: st <= TX_IDLE;
         endcase
      end
   end

   p_hold_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
   p_valid_needs_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> active);
   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> !tx_done);
   p_wb_clears_own_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && m_we) |-> !m_wdata[OWN_B]);
endmodule

// File: rtl/dring_dma.sv
module dring_dma
   import dring_pkg::*;
#(
   parameter int AW        = 16,
   parameter int IDX_W     = 6,
   parameter int BUF_BYTES = 128,
   parameter int MAX_FRAME = 1522
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rx_ring_base,
   input  logic [AW-1:0] tx_ring_base,
   input  logic          rx_poll_wr,
   input  logic          tx_poll_wr,
   input  logic [31:0]   poll_wdata,
   output logic          rx_active,
   output logic          tx_active,
   output logic          rxm_req,
   output logic          rxm_we,
   output logic [AW-1:0] rxm_addr,
   output logic [31:0]   rxm_wdata,
   input  logic [31:0]   rxm_rdata,
   output logic          txm_req,
   output logic          txm_we,
   output logic [AW-1:0] txm_addr,
   output logic [31:0]   txm_wdata,
   input  logic [31:0]   txm_rdata,
   input  logic          rx_valid,
   input  logic [7:0]    rx_data,
   input  logic          rx_last,
   input  logic          rx_err,
   output logic          rx_ready,
   output logic          tx_valid,
   output logic [7:0]    tx_data,
   output logic          tx_last,
   output logic          tx_crc,
   input  logic          tx_ready,
   output logic          rx_done,
   output logic          tx_done
);
   generate
      if (AW < IDX_W + 1) begin : g_bad_aw
         $error("AW too narrow for the descriptor index");
      end
      if (BUF_BYTES < 2 || BUF_BYTES > 65535) begin : g_bad_buf
         $error("BUF_BYTES out of range");
      end
      if (MAX_FRAME < 1 || MAX_FRAME > 65535) begin : g_bad_max
         $error("MAX_FRAME out of range");
      end
   endgenerate

   logic [AW-1:0] rx_desc, tx_desc;
   logic          rx_stop, rx_adv, rx_wrap;
   logic          tx_stop, tx_adv, tx_wrap;

   dring_ptr #(.AW(AW), .IDX_W(IDX_W)) u_rx_ptr (
      .clk, .rst_n, .base(rx_ring_base), .poll_wr(rx_poll_wr), .poll_data(poll_wdata),
      .stop(rx_stop), .advance(rx_adv), .wrap_now(rx_wrap),
      .active(rx_active), .desc_addr(rx_desc)
   );

   dring_ptr #(.AW(AW), .IDX_W(IDX_W)) u_tx_ptr (
      .clk, .rst_n, .base(tx_ring_base), .poll_wr(tx_poll_wr), .poll_data(poll_wdata),
      .stop(tx_stop), .advance(tx_adv), .wrap_now(tx_wrap),
      .active(tx_active), .desc_addr(tx_desc)
   );

   dring_rx #(.AW(AW), .BUF_BYTES(BUF_BYTES), .MAX_FRAME(MAX_FRAME)) u_rx (
      .clk, .rst_n, .active(rx_active), .desc_addr(rx_desc),
      .stop(rx_stop), .advance(rx_adv), .wrap_now(rx_wrap),
      .rx_valid, .rx_data, .rx_last, .rx_err, .rx_ready, .rx_done,
      .m_req(rxm_req), .m_we(rxm_we), .m_addr(rxm_addr),
      .m_wdata(rxm_wdata), .m_rdata(rxm_rdata)
   );

   dring_tx #(.AW(AW)) u_tx (
      .clk, .rst_n, .active(tx_active), .desc_addr(tx_desc),
      .stop(tx_stop), .advance(tx_adv), .wrap_now(tx_wrap),
      .tx_valid, .tx_data, .tx_last, .tx_crc, .tx_ready, .tx_done,
      .m_req(txm_req), .m_we(txm_we), .m_addr(txm_addr),
      .m_wdata(txm_wdata), .m_rdata(txm_rdata)
   );

   p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_active && !tx_active && $past(!rx_active && !tx_active)) |-> (!rx_ready && !tx_valid));
endmodule

// File: tb/sim_dring_dma.sv
module sim_dring_dma;
   localparam int AW = 12;
   localparam logic [AW-1:0] RXB = 12'h100;
   localparam logic [AW-1:0] TXB = 12'h080;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic [AW-1:0] rx_ring_base = RXB, tx_ring_base = TXB;
   logic rx_poll_wr = 0, tx_poll_wr = 0;
   logic [31:0] poll_wdata = 0;
   logic rx_active, tx_active;
   logic rxm_req, rxm_we, txm_req, txm_we;
   logic [AW-1:0] rxm_addr, txm_addr;
   logic [31:0] rxm_wdata, txm_wdata;
   logic [31:0] rxm_rdata = 0, txm_rdata = 0;
   logic rx_valid = 0, rx_last = 0, rx_err = 0, rx_ready;
   logic [7:0] rx_data = 0;
   logic tx_valid, tx_last, tx_crc;
   logic tx_ready = 0;
   logic [7:0] tx_data;
   logic rx_done, tx_done;

   dring_dma #(.AW(AW), .IDX_W(3), .BUF_BYTES(8), .MAX_FRAME(20)) u0 (.*);

   // behavioural memory, one-cycle read latency on each port
   logic [31:0] mem [0:4095];
   logic tbw_en = 0;
   logic [AW-1:0] tbw_addr = 0;
   logic [31:0] tbw_data = 0;
   always @(posedge clk) begin
      if (tbw_en) mem[tbw_addr] <= tbw_data;
      if (rxm_req) begin
         if (rxm_we) mem[rxm_addr] <= rxm_wdata;
         else rxm_rdata <= mem[rxm_addr];
      end
      if (txm_req) begin
         if (txm_we) mem[txm_addr] <= txm_wdata;
         else txm_rdata <= mem[txm_addr];
      end
   end

   int n_chk = 0, n_fail = 0;
   int rx_done_cnt = 0, tx_done_cnt = 0, tx_bytes = 0, cyc = 0;
   logic prev_rx_done = 0, prev_tx_done = 0;
   logic [9:0] txq [$];   // {last, crc, data}

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] w0(input bit own, input bit wrap, input bit last,
                                      input bit tc, input bit err, input int len);
      logic [31:0] v = '0;
      v[31] = own; v[29] = wrap; v[27] = last; v[26] = tc; v[16] = err;
      v[15:0] = 16'(len);
      return v;
   endfunction

   task automatic mwrite(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk); tbw_en = 1; tbw_addr = a; tbw_data = d;
      @(negedge clk); tbw_en = 0;
   endtask

   task automatic poll_rx(input logic [31:0] d);
      @(negedge clk); rx_poll_wr = 1; poll_wdata = d;
      @(negedge clk); rx_poll_wr = 0; poll_wdata = 0;
   endtask

   task automatic poll_tx(input logic [31:0] d);
      @(negedge clk); tx_poll_wr = 1; poll_wdata = d;
      @(negedge clk); tx_poll_wr = 0; poll_wdata = 0;
   endtask

   task automatic send(input logic [7:0] b0, input int n, input bit last, input bit err);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_valid = 1; rx_data = b0 + 8'(i);
         rx_last = last && (i == n - 1); rx_err = err && (i == n - 1);
         while (!rx_ready) @(negedge clk);
      end
      @(negedge clk); rx_valid = 0; rx_last = 0; rx_err = 0;
   endtask

   // per-clock reference monitor: done pulse width, transmit stream contents
   always @(negedge clk) begin
      cyc++;
      tx_ready = (cyc % 3) != 1;
      if (rst_n) begin
         if (rx_done) begin
            rx_done_cnt++;
            if (prev_rx_done) check("R10 rx_done width", 1, 0);
         end
         if (tx_done) begin
            tx_done_cnt++;
            if (prev_tx_done) check("R10 tx_done width", 1, 0);
         end
         if (tx_valid && tx_ready) begin
            tx_bytes++;
            if (txq.size() == 0) check("R8 unexpected tx byte", {22'd0, tx_last, tx_crc, tx_data}, 0);
            else check("R8 tx byte/last/crc", {22'd0, tx_last, tx_crc, tx_data}, {22'd0, txq.pop_front()});
         end
      end
      prev_rx_done = rx_done;
      prev_tx_done = tx_done;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 rx_active", rx_active, 0);
      check("R1 tx_active", tx_active, 0);
      check("R1 rx_ready", rx_ready, 0);
      check("R1 tx_valid", tx_valid, 0);
      check("R1 done", {rx_done, tx_done}, 0);
      @(negedge clk); rst_n = 1;

      // receive ring: d0,d1 empty, d2 held by software, d3 empty with wrap
      mwrite(RXB + 0, w0(1,0,0,0,0,0)); mwrite(RXB + 1, 32'h200);
      mwrite(RXB + 2, w0(1,0,0,0,0,0)); mwrite(RXB + 3, 32'h210);
      mwrite(RXB + 4, w0(0,0,0,0,0,0)); mwrite(RXB + 5, 32'h220);
      mwrite(RXB + 6, w0(1,1,0,0,0,0)); mwrite(RXB + 7, 32'h230);
      repeat (2) @(negedge clk);
      check("R1 rx_ready after reset", rx_ready, 0);

      // R2: poll with bit 24 clear is ignored; with bit 24 set activates
      poll_rx(32'h0000_0001);
      repeat (3) @(negedge clk);
      check("R2 no-op poll", rx_active, 0);
      poll_rx(32'h0100_0000);
      check("R2 poll activates", rx_active, 1);

      // frame A: 5 bytes into d0
      send(8'h10, 5, 1, 0);
      repeat (6) @(negedge clk);
      check("R4 d0 writeback", mem[RXB + 0], w0(0,0,1,0,0,5));
      check("R5 d0 byte0", mem[12'h200], 32'h10);
      check("R5 d0 byte4", mem[12'h204], 32'h14);
      check("R10 rx_done count A", rx_done_cnt, 1);

      // frame B part 1: fills d1, then d2 is not owned
      send(8'h30, 8, 0, 0);
      repeat (8) @(negedge clk);
      check("R4 d1 full buffer", mem[RXB + 2], w0(0,0,0,0,0,8));
      check("R3 ring stops", rx_active, 0);
      check("R3 ready low", rx_ready, 0);
      check("R3 d2 untouched", mem[RXB + 4], w0(0,0,0,0,0,0));
      check("R10 no done mid-frame", rx_done_cnt, 1);

      // software returns d2, polls; rest of frame B
      mwrite(RXB + 4, w0(1,0,0,0,0,0));
      poll_rx(32'h0100_0000);
      send(8'h38, 2, 1, 0);
      repeat (6) @(negedge clk);
      check("R4 d2 final length", mem[RXB + 4], w0(0,0,1,0,0,10));
      check("R5 d2 byte1", mem[12'h221], 32'h39);
      check("R10 rx_done count B", rx_done_cnt, 2);

      // frame C: 25 bytes, limit 20; d3 (wrap) -> d0 -> d1
      mwrite(RXB + 0, w0(1,0,0,0,0,0));
      mwrite(RXB + 2, w0(1,0,0,0,0,0));
      send(8'h50, 25, 1, 0);
      repeat (6) @(negedge clk);
      check("R6 d3 keeps wrap", mem[RXB + 6], w0(0,1,0,0,0,8));
      check("R6 wrapped to d0", mem[RXB + 0], w0(0,0,0,0,0,8));
      check("R7 oversize final", mem[RXB + 2], w0(0,0,1,0,1,20));
      check("R5 d1 byte3", mem[12'h213], 32'h63);
      check("R7 d0 byte0", mem[12'h200], 32'h58);

      // frame D: error flagged on last byte, into d2
      mwrite(RXB + 4, w0(1,0,0,0,0,0));
      poll_rx(32'h0100_0000);
      send(8'h90, 3, 1, 1);
      repeat (8) @(negedge clk);
      check("R7 rx_err flag", mem[RXB + 4], w0(0,0,1,0,1,3));
      check("R10 rx_done count D", rx_done_cnt, 4);
      check("R3 stops at used d3", rx_active, 0);

      // transmit ring
      mwrite(TXB + 0, w0(1,0,1,1,0,4)); mwrite(TXB + 1, 32'h400);
      mwrite(TXB + 2, w0(1,0,0,0,0,3)); mwrite(TXB + 3, 32'h410);
      mwrite(TXB + 4, w0(1,1,1,0,0,2)); mwrite(TXB + 5, 32'h420);
      for (int i = 0; i < 4; i++) mwrite(12'h400 + 12'(i), 32'hA0 + i);
      for (int i = 0; i < 3; i++) mwrite(12'h410 + 12'(i), 32'hB0 + i);
      for (int i = 0; i < 2; i++) mwrite(12'h420 + 12'(i), 32'hC0 + i);
      for (int i = 0; i < 4; i++) txq.push_back({i == 3, 1'b1, 8'hA0 + 8'(i)});
      for (int i = 0; i < 3; i++) txq.push_back({1'b0, 1'b0, 8'hB0 + 8'(i)});
      for (int i = 0; i < 2; i++) txq.push_back({i == 1, 1'b0, 8'hC0 + 8'(i)});
      check("R8 tx idle before poll", tx_valid, 0);
      poll_tx(32'h0100_0000);
      repeat (150) @(negedge clk);
      check("R8 byte count", tx_bytes, 9);
      check("R9 d0 writeback", mem[TXB + 0], w0(0,0,1,1,0,4));
      check("R9 d1 writeback", mem[TXB + 2], w0(0,0,0,0,0,3));
      check("R9 d2 writeback", mem[TXB + 4], w0(0,1,1,0,0,2));
      check("R10 tx_done count", tx_done_cnt, 2);
      check("R8 stops at used d0", tx_active, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule